// File: doc/BRIEF.md
# Protected Handler RAM Address Decoder

This block sits between a processor's physical address bus and the memory system. For each request it decides whether the access goes to a dedicated protected RAM or to ordinary system memory. The protected RAM holds the handler that runs in a special processor mode, and the processor state that is saved when that mode is entered. The decoder holds three settings, changed by single-cycle register writes: a base address, a window size, and an "open" control. After reset the base is 0x30000, the window is 64 KB and the open control is clear.

The window is the block of the programmed size, aligned to that size, that contains base + 0x8000. For a base aligned to 64 KB or more, it always covers base + 0x8000 through base + 0xFFFF. An access that matches the window goes to the protected RAM only while the processor reports that it is in the special mode, or while the open control is set. The open control lets start-up code load the handler from normal operation. Any other access goes to system memory. A matching access that is refused also raises a one-cycle violation flag. Accesses sent to the RAM carry their offset within the window. Two flags mark them further: one for a fetch at the handler entry point, one for an access in the state-save area.

Top module: `smram_decoder`

## Requirements
- R1: After reset the base is 0x30000, the size is 64 KB, the open control is clear, and every output is low or zero.
- R2: Outputs are registered. A request presented before a clock edge produces its result after that edge, and exactly one of ram_sel and mem_sel is high. With no request, both are low after the edge.
- R3: An address matches when its bits at and above log2(size) equal those of base + 0x8000. A matching access goes to the RAM when smm_act is high. Every non-matching access goes to system memory.
- R4: While ram_sel is high, ram_ofs equals the address masked with size - 1. ram_ofs is zero whenever ram_sel is low.
- R5: A matching access with smm_act low and the open control clear goes to system memory. prot_viol is then high for that one result cycle only.
- R6: A write with cfg_addr = 2 sets the open control from cfg_wdata bit 0. While it is set, matching accesses go to the RAM even with smm_act low, and prot_viol stays low.
- R7: A write with cfg_addr = 1 sets the size in bytes from cfg_wdata. Only a single set bit in positions 15 through 32 (32 KB to 4 GB) is accepted. Any other value is ignored and the old size is kept.
- R8: A write with cfg_addr = 0 loads the base from cfg_wdata bits 31:0. The write takes effect for requests on the following cycle.
- R9: entry_hit is high for a fetch to exactly base + 0x8000 that goes to the RAM.
- R10: save_hit is high for an access that goes to the RAM and whose address minus base lies in 0xFE00 through 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Address request strobe |
| addr | input | 32 | Physical address |
| fetch | input | 1 | Request is an instruction fetch |
| smm_act | input | 1 | Processor is in the special mode |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 2 | Setting select: 0 base, 1 size, 2 open |
| cfg_wdata | input | 33 | Setting write value |
| ram_sel | output | 1 | Access goes to the protected RAM |
| mem_sel | output | 1 | Access goes to system memory |
| ram_ofs | output | 32 | Offset within the window |
| entry_hit | output | 1 | Fetch at the handler entry point |
| save_hit | output | 1 | Access in the state-save area |
| prot_viol | output | 1 | Refused access to the window |

## Verification
The assertions assume that req and the mode qualifier are clean, known levels on every clock after reset. They also assume that a setting write and a request never share a cycle, so each result reflects one settled setting. The bench drives inputs only on falling edges and always leaves an idle cycle after a setting write. It holds req low throughout reset, so every registered result traces back to a single request made under stable settings.

// File: rtl/smram_decoder.sv
module smram_decoder #(
  parameter int AW = 32,
  parameter logic [AW-1:0] DEF_BASE = 32'h0003_0000,
  parameter int DEF_LG = 16,
  parameter int MIN_LG = 15,
  parameter logic [AW-1:0] ENTRY_OFS = 32'h0000_8000,
  parameter logic [AW-1:0] SAVE_LO = 32'h0000_FE00,
  parameter logic [AW-1:0] SAVE_HI = 32'h0000_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] addr,
  input  logic          fetch,
  input  logic          smm_act,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [AW:0]   cfg_wdata,
  output logic          ram_sel,
  output logic          mem_sel,
  output logic [AW-1:0] ram_ofs,
  output logic          entry_hit,
  output logic          save_hit,
  output logic          prot_viol
);

  localparam logic [AW:0]   ONE_W    = {{AW{1'b0}}, 1'b1};
  localparam logic [AW-1:0] DEF_MASK = AW'((ONE_W << DEF_LG) - ONE_W);

  logic [AW-1:0] base_q, mask_q;
  logic          open_q;

  logic [AW:0]   size_m1;
  logic          size_ok;
  assign size_m1 = cfg_wdata - ONE_W;
  assign size_ok = $onehot(cfg_wdata) && (cfg_wdata[MIN_LG-1:0] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= DEF_BASE;
      mask_q <= DEF_MASK;
      open_q <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: base_q <= cfg_wdata[AW-1:0];
        2'd1: if (size_ok) mask_q <= size_m1[AW-1:0];
        2'd2: open_q <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  logic [AW-1:0] anchor, rel;
  logic          hit, grant, to_ram, is_entry, is_save;

  assign anchor   = base_q + ENTRY_OFS;
  assign rel      = addr - base_q;
  assign hit      = ((addr ^ anchor) & ~mask_q) == '0;
  assign grant    = smm_act | open_q;
  assign to_ram   = req & hit & grant;
  assign is_entry = fetch && (addr == anchor);
  assign is_save  = (rel >= SAVE_LO) && (rel <= SAVE_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_sel   <= 1'b0;
      mem_sel   <= 1'b0;
      ram_ofs   <= '0;
      entry_hit <= 1'b0;
      save_hit  <= 1'b0;
      prot_viol <= 1'b0;
    end else begin
      ram_sel   <= to_ram;
      mem_sel   <= req & ~to_ram;
      ram_ofs   <= to_ram ? (addr & mask_q) : '0;
      entry_hit <= to_ram & is_entry;
      save_hit  <= to_ram & is_save;
      prot_viol <= req & hit & ~grant;
    end
  end

endmodule

// File: rtl/smram_decoder_chk.sv
module smram_decoder_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          smm_act,
  input logic          open_q,
  input logic [AW-1:0] mask_q,
  input logic          ram_sel,
  input logic          mem_sel,
  input logic [AW-1:0] ram_ofs,
  input logic          entry_hit,
  input logic          save_hit,
  input logic          prot_viol
);

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r2_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(req) |-> (ram_sel ^ mem_sel));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(req) |-> !ram_sel && !mem_sel);

  a_r5_viol_on_mem: assert property (@(posedge clk) disable iff (!rst_n)
    prot_viol |-> mem_sel && !ram_sel);

  a_r6_ram_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    armed && ram_sel |-> $past(smm_act) || $past(open_q));

  a_r4_ofs_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_sel |-> ram_ofs == '0);

  a_r4_ofs_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    armed && ram_sel |-> (ram_ofs & ~$past(mask_q)) == '0);

  a_r9_entry_in_ram: assert property (@(posedge clk) disable iff (!rst_n)
    entry_hit |-> ram_sel);

  a_r10_save_in_ram: assert property (@(posedge clk) disable iff (!rst_n)
    save_hit |-> ram_sel);

endmodule

bind smram_decoder smram_decoder_chk #(.AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .req(req), .smm_act(smm_act),
  .open_q(open_q), .mask_q(mask_q), .ram_sel(ram_sel), .mem_sel(mem_sel),
  .ram_ofs(ram_ofs), .entry_hit(entry_hit), .save_hit(save_hit),
  .prot_viol(prot_viol)
);

// File: tb/smram_decoder_test.sv
module smram_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] addr = '0;
  logic        fetch = 1'b0;
  logic        smm_act = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [32:0] cfg_wdata = '0;
  logic        ram_sel, mem_sel, entry_hit, save_hit, prot_viol;
  logic [31:0] ram_ofs;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  smram_decoder uut (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .fetch(fetch),
    .smm_act(smm_act), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ram_sel(ram_sel), .mem_sel(mem_sel),
    .ram_ofs(ram_ofs), .entry_hit(entry_hit), .save_hit(save_hit),
    .prot_viol(prot_viol)
  );

  typedef struct packed {
    logic        smm;
    logic        fe;
    logic [31:0] a;
    logic        ram;
    logic        mem;
    logic [31:0] ofs;
    logic        ent;
    logic        sav;
    logic        vio;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 32'h0003_0000, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 32'h0003_FFFF, 1'b1, 1'b0, 32'h0000_FFFF, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b1, 32'h0003_8000, 1'b1, 1'b0, 32'h0000_8000, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 32'h0003_8000, 1'b1, 1'b0, 32'h0000_8000, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 32'h0003_FE00, 1'b1, 1'b0, 32'h0000_FE00, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b0, 32'h0003_FDFF, 1'b1, 1'b0, 32'h0000_FDFF, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 32'h0004_0000, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 32'h0002_FFFF, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 32'h0003_8000, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b1},
    '{1'b0, 1'b0, 32'h0005_0000, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [32:0] val);
    cfg_we = 1'b1; cfg_addr = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic run(input vec_t v);
    req = 1'b1; addr = v.a; fetch = v.fe; smm_act = v.smm;
    #1;
    chk("R2 latency ram_sel", {31'b0, ram_sel}, 32'd0);
    chk("R2 latency mem_sel", {31'b0, mem_sel}, 32'd0);
    @(negedge clk);
    chk("R3 ram_sel", {31'b0, ram_sel}, {31'b0, v.ram});
    chk("R3 mem_sel", {31'b0, mem_sel}, {31'b0, v.mem});
    chk("R4 ram_ofs", ram_ofs, v.ofs);
    chk("R9 entry_hit", {31'b0, entry_hit}, {31'b0, v.ent});
    chk("R10 save_hit", {31'b0, save_hit}, {31'b0, v.sav});
    chk("R5 prot_viol", {31'b0, prot_viol}, {31'b0, v.vio});
    req = 1'b0; fetch = 1'b0;
    @(negedge clk);
  endtask

  function automatic vec_t mk(input logic smm, input logic fe, input logic [31:0] a,
                              input logic ram, input logic [31:0] ofs,
                              input logic ent, input logic sav, input logic vio);
    mk = '{smm, fe, a, ram, ~ram, ofs, ent, sav, vio};
  endfunction

  initial begin
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ram_sel in reset", {31'b0, ram_sel}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mem_sel", {31'b0, mem_sel}, 32'd0);
    chk("R1 ram_ofs", ram_ofs, 32'd0);
    chk("R2 idle", {30'b0, ram_sel, mem_sel}, 32'd0);
    chk("R1 flags", {29'b0, entry_hit, save_hit, prot_viol}, 32'd0);

    for (int i = 0; i < NV; i++) run(VEC[i]);

    // R5: violation lasts one cycle
    run(mk(1'b0, 1'b0, 32'h0003_1234, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1));
    chk("R5 prot_viol one cycle", {31'b0, prot_viol}, 32'd0);

    // R6: open control
    cfg(2'd2, 33'd1);
    run(mk(1'b0, 1'b1, 32'h0003_8000, 1'b1, 32'h0000_8000, 1'b1, 1'b0, 1'b0));
    run(mk(1'b0, 1'b0, 32'h0006_0000, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0));
    cfg(2'd2, 33'd0);
    run(mk(1'b0, 1'b0, 32'h0003_0010, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1));

    // R7: invalid sizes ignored
    cfg(2'd1, 33'h0_0003_0000);
    run(mk(1'b1, 1'b0, 32'h0002_0000, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0));
    cfg(2'd1, 33'h0_0000_4000);
    run(mk(1'b1, 1'b0, 32'h0003_C000, 1'b1, 32'h0000_C000, 1'b0, 1'b0, 1'b0));
    cfg(2'd1, 33'h0_0000_0000);
    run(mk(1'b1, 1'b0, 32'h0003_0004, 1'b1, 32'h0000_0004, 1'b0, 1'b0, 1'b0));

    // R7: 32 KB window covers base+0x8000..base+0xFFFF only
    cfg(2'd1, 33'h0_0000_8000);
    run(mk(1'b1, 1'b0, 32'h0003_0000, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0));
    run(mk(1'b1, 1'b0, 32'h0003_8004, 1'b1, 32'h0000_0004, 1'b0, 1'b0, 1'b0));
    run(mk(1'b1, 1'b0, 32'h0003_FF00, 1'b1, 32'h0000_7F00, 1'b0, 1'b1, 1'b0));

    // R3: 1 MB window aligned to its size
    cfg(2'd1, 33'h0_0010_0000);
    run(mk(1'b1, 1'b0, 32'h000F_0000, 1'b1, 32'h000F_0000, 1'b0, 1'b0, 1'b0));
    run(mk(1'b1, 1'b0, 32'h0010_0000, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0));

    // R7: 4 GB window claims everything
    cfg(2'd1, 33'h1_0000_0000);
    run(mk(1'b1, 1'b0, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0));
    run(mk(1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0));

    // R8: new base with 64 KB window
    cfg(2'd1, 33'h0_0001_0000);
    cfg(2'd0, 33'h0_000A_0000);
    run(mk(1'b1, 1'b1, 32'h000A_8000, 1'b1, 32'h0000_8000, 1'b1, 1'b0, 1'b0));
    run(mk(1'b1, 1'b0, 32'h000A_FFF0, 1'b1, 32'h0000_FFF0, 1'b0, 1'b1, 1'b0));
    run(mk(1'b1, 1'b1, 32'h0003_8000, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule